// File: doc/BRIEF.md
# Ten-Bit Addressed I2C Target Interface

This block is the target (slave) end of a two-wire serial bus, answering to a 10-bit device address that arrives as an input port. The clock and data lines are brought into the system clock domain through a flop chain and then sampled. From the sampled lines the block finds START, repeated START and STOP conditions and rising and falling clock edges. The address is split over two bytes. The first byte after a START carries a fixed 11110 prefix, the two upper address bits and the direction bit. The second byte carries the lower eight address bits. SDA is driven only through an active-high pull-low enable, because the wire is open-drain.

After both address bytes match, the block is fully addressed. Every further byte of that write is acknowledged and handed to the host logic as a one-cycle valid pulse. The fully addressed flag survives a repeated START. A read is opened by a repeated START followed by the first address byte alone, with the direction bit set. The block accepts that read header only if it holds a full match. It then sends bytes taken from a data port, announcing each fetch with a one-cycle request pulse, and stops driving once the controller answers a byte with NACK.

The state machine has eight states. IDLE waits for a START. HDR shifts in the first address byte. LOW shifts in the lower address byte. WDATA shifts in write data. ACK holds SDA low for one acknowledge bit and then moves on to the state it remembered. RDATA shifts a byte out. RACK samples the controller's acknowledge. IGNORE stays off the bus until the next START or STOP.

The transitions are:
- START: any state to HDR.
- STOP: any state to IDLE.
- HDR to ACK: on a header match that is a write, or a read while fully addressed.
- HDR to IGNORE: on any other header.
- LOW to ACK: when the low byte matches.
- LOW to IGNORE: when it does not.
- WDATA to ACK: after every byte.
- ACK to LOW, WDATA or RDATA: on the falling clock edge that ends the acknowledge bit.
- RDATA to RACK: after eight bits.
- RACK to RDATA: on a controller ACK.
- RACK to IGNORE: on a controller NACK.

Top module: `i2c_tenbit_slave`

## Requirements
- R1: While reset is asserted and right after it, sda_pull, rx_valid, tx_req and full_match are all 0.
- R2: A first byte equal to {11110, dev_addr[9:8], 0} after a START is acknowledged by pulling SDA low during the ninth clock. A first byte with a different prefix or different upper bits is not acknowledged.
- R3: A second byte equal to dev_addr[7:0] is acknowledged and sets full_match to 1. A mismatching second byte is NACKed and clears full_match. After that NACK, later bytes get no acknowledge and no rx_valid until the next START.
- R4: Each write data byte after a full match is acknowledged and appears once on rx_data, MSB first on the wire, with rx_valid high for exactly one cycle.
- R5: After a repeated START, a first byte equal to {11110, dev_addr[9:8], 1} is acknowledged only while full_match is 1. Otherwise it is NACKed.
- R6: In a read, each byte is taken from tx_data in the cycle that tx_req pulses and is shifted out MSB first. A controller ACK on the ninth clock causes the next fetch.
- R7: A controller NACK after a read byte ends the read. The block then leaves SDA released and makes no further fetch until the next START or STOP.
- R8: A STOP clears full_match, so a read header after a fresh START without a new full match is NACKed.
- R9: sda_pull changes only while SCL is low.
- R10: SDA falling while SCL is high is a START even in the middle of a byte, and it restarts first-byte reception from bit 7. SDA rising while SCL is high is a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 10 | Ten-bit address this target answers to |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| sda_pull | output | 1 | High pulls SDA low; low releases the line |
| rx_valid | output | 1 | One-cycle pulse when a write byte has been received |
| rx_data | output | 8 | Received write byte, valid while rx_valid is high |
| tx_data | input | 8 | Next byte to send in a read |
| tx_req | output | 1 | One-cycle pulse in the cycle tx_data is captured |
| full_match | output | 1 | Both address bytes matched since the last STOP or failed low byte |

## Verification
The checks assume that every bus low or high phase lasts longer than the synchronizer depth plus one cycle. Under that assumption, SDA edges caused by the block fall inside an SCL low phase. The checks also assume the controller never moves SDA while SCL is high, except to form START or STOP. The bench's controller model keeps every quarter bit at eight system clocks and changes its own SDA only during SCL low phases. It uses SDA moves with SCL high only in its START, repeated START and STOP tasks, one of which is issued deliberately in the middle of a byte.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_LOW,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } state_t;

endpackage

// File: rtl/i2c10_sync.sv
module i2c10_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] d,
    output logic [LINES-1:0] q
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2:0], d[g]};
            end
        end

        assign q[g] = chain[STAGES-1];
    end

endmodule

// File: rtl/i2c10_cond.sv
module i2c10_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s && !scl_q;
        scl_fall  = !scl_s && scl_q;
        start_det = scl_s && scl_q && sda_q && !sda_s;
        stop_det  = scl_s && scl_q && !sda_q && sda_s;
    end

endmodule

// File: rtl/i2c_tenbit_slave.sv
module i2c_tenbit_slave
    import i2c10_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_data,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    output logic              full_match
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    logic [1:0] line_s;
    logic       scl_s;
    logic       sda_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    state_t            state_q;
    state_t            state_d;
    state_t            after_q;
    state_t            after_d;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              full_q;
    logic              mnack_q;

    logic hdr_hit;
    logic rw_bit;
    logic low_hit;
    logic byte_in;

    i2c10_sync #(
        .STAGES (SYNC_STAGES),
        .LINES  (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    i2c10_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    // byte decode
    always_comb begin
        hdr_hit = (shreg[BYTE_W-1:3] == TEN_BIT_PREFIX) &&
                  (shreg[2:1] == dev_addr[ADDR_W-1:BYTE_W]);
        rw_bit  = shreg[0];
        low_hit = (shreg == dev_addr[BYTE_W-1:0]);
        byte_in = scl_fall && (cnt == LAST_RX);
    end

    // next state
    always_comb begin
        state_d = state_q;
        after_d = after_q;
        if (start_det) begin
            state_d = ST_HDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                    state_d = state_q;
                end
                ST_HDR: begin
                    if (byte_in) begin
                        if (hdr_hit && (!rw_bit || full_q)) begin
                            state_d = ST_ACK;
                            after_d = rw_bit ? ST_RDATA : ST_LOW;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                ST_LOW: begin
                    if (byte_in) begin
                        state_d = low_hit ? ST_ACK : ST_IGNORE;
                        after_d = ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (byte_in) begin
                        state_d = ST_ACK;
                        after_d = ST_WDATA;
                    end
                end
                ST_ACK: begin
                    if (scl_fall) state_d = after_q;
                end
                ST_RDATA: begin
                    if (scl_fall && (cnt == LAST_TX)) state_d = ST_RACK;
                end
                ST_RACK: begin
                    if (scl_fall) state_d = mnack_q ? ST_IGNORE : ST_RDATA;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            after_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
            after_q <= after_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            full_q   <= 1'b0;
            mnack_q  <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
            tx_req   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (start_det) begin
                cnt <= '0;
            end else if (stop_det) begin
                cnt    <= '0;
                full_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_HDR, ST_LOW, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 1'b1;
                        end
                        if (byte_in) begin
                            cnt <= '0;
                            if (state_q == ST_LOW) full_q <= low_hit;
                            if (state_q == ST_WDATA) begin
                                rx_valid <= 1'b1;
                                rx_data  <= shreg;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (after_q == ST_RDATA) begin
                                shreg  <= tx_data;
                                tx_req <= 1'b1;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            cnt   <= cnt + 1'b1;
                            shreg <= {shreg[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mnack_q <= sda_s;
                        if (scl_fall && !mnack_q) begin
                            shreg  <= tx_data;
                            tx_req <= 1'b1;
                            cnt    <= '0;
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        cnt <= '0;
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_pull   = (state_q == ST_ACK) ||
                     ((state_q == ST_RDATA) && !shreg[BYTE_W-1]);
        full_match = full_q;
    end

endmodule

// File: rtl/i2c10_checker.sv
module i2c10_checker
    import i2c10_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   scl_i,
    input logic   sda_pull,
    input logic   rx_valid,
    input logic   tx_req,
    input logic   full_match,
    input logic   stop_det,
    input state_t state_q
);

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull)); // R9

    AST_RX_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> full_match); // R4

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4

    AST_TX_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> full_match); // R6

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !full_match); // R8

    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE || state_q == ST_IDLE) |-> !sda_pull); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid && !tx_req)); // R1

endmodule

bind i2c_tenbit_slave i2c10_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_pull   (sda_pull),
    .rx_valid   (rx_valid),
    .tx_req     (tx_req),
    .full_match (full_match),
    .stop_det   (stop_det),
    .state_q    (state_q)
);

// File: tb/tb_i2c_tenbit_slave.sv
module tb_i2c_tenbit_slave;

    localparam int Q = 8;
    localparam logic [9:0] ADDR = 10'h2B5;
    localparam logic [7:0] HDR_W = 8'hF4;
    localparam logic [7:0] HDR_R = 8'hF5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_pull;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic [7:0] tx_data;
    logic       tx_req;
    logic       full_match;
    logic       sda_bus;

    logic [7:0] tx_bytes [4] = '{8'hC3, 8'h5A, 8'h81, 8'hEE};
    int         tx_idx = 0;
    logic [7:0] rx_exp [$];
    logic [7:0] rd_exp [$];
    int         tests = 0;
    int         fails = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    assign sda_bus = !(m_low || sda_pull);
    assign tx_data = tx_bytes[tx_idx % 4];

    i2c_tenbit_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_addr   (ADDR),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .sda_pull   (sda_pull),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .tx_data    (tx_data),
        .tx_req     (tx_req),
        .full_match (full_match)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 0; scl = 1; wq(1);
        m_low = 1; wq(1);
        scl = 0; wq(1);
    endtask

    task automatic bus_rstart();
        m_low = 0; wq(1);
        scl = 1; wq(1);
        m_low = 1; wq(1);
        scl = 0; wq(1);
    endtask

    task automatic bus_stop();
        m_low = 1; wq(1);
        scl = 1; wq(1);
        m_low = 0; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = !b[i]; wq(1);
            scl = 1; wq(2);
            scl = 0; wq(1);
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_low = 0; wq(1);
        scl = 1; wq(1);
        ack = !sda_bus; wq(1);
        scl = 0; wq(1);
    endtask

    task automatic read_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_low = 0; wq(1);
            scl = 1; wq(1);
            b[i] = sda_bus; wq(1);
            scl = 0; wq(1);
        end
        m_low = !nack; wq(1);
        scl = 1; wq(2);
        scl = 0; wq(1);
        m_low = 0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_exp.size() == 0) begin
                check(0, "R4", "unexpected rx byte", int'(rx_data), 0);
            end else begin
                logic [7:0] e;
                e = rx_exp.pop_front();
                check(rx_data == e, "R4", "rx byte", int'(rx_data), int'(e));
            end
        end
        if (rst_n && tx_req) begin
            rd_exp.push_back(tx_data);
            tx_idx++;
        end
    end

    task automatic wr_expect(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        if (exp_ack) rx_exp.push_back(b);
        write_byte(b, a);
        check(a == exp_ack, req, "write ack", int'(a), int'(exp_ack));
    endtask

    task automatic hdr(input logic [7:0] b, input bit exp_ack, input string req);
        bit a;
        write_byte(b, a);
        check(a == exp_ack, req, "address ack", int'(a), int'(exp_ack));
    endtask

    task automatic rd_expect(input bit nack, input string req);
        logic [7:0] got;
        logic [7:0] e;
        read_byte(nack, got);
        e = (rd_exp.size() != 0) ? rd_exp.pop_front() : 8'hXX;
        check(got === e, req, "read byte", int'(got), int'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(sda_pull == 0, "R1", "sda_pull in reset", int'(sda_pull), 0);
        check(full_match == 0, "R1", "full_match in reset", int'(full_match), 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check(rx_valid == 0 && tx_req == 0, "R1", "pulses after reset",
              int'({rx_valid, tx_req}), 0);
        check(full_match == 0, "R1", "full_match after reset", int'(full_match), 0);

        // write transfer: R2 R3 R4
        bus_start();
        hdr(HDR_W, 1, "R2");
        hdr(ADDR[7:0], 1, "R3");
        check(full_match == 1, "R3", "full_match after low byte", int'(full_match), 1);
        wr_expect(8'h3C, 1, "R4");
        wr_expect(8'hA5, 1, "R4");
        wr_expect(8'h00, 1, "R4");
        wr_expect(8'hFF, 1, "R4");
        bus_stop();
        check(full_match == 0, "R8", "full_match after stop", int'(full_match), 0);
        check(rx_exp.size() == 0, "R4", "rx bytes outstanding", rx_exp.size(), 0);

        // read transfer: R5 R6 R7
        bus_start();
        hdr(HDR_W, 1, "R2");
        hdr(ADDR[7:0], 1, "R3");
        bus_rstart();
        hdr(HDR_R, 1, "R5");
        rd_expect(0, "R6");
        rd_expect(0, "R6");
        rd_expect(1, "R6");
        check(tx_idx == 3, "R6", "fetch count", tx_idx, 3);
        read_byte(0, b);
        check(b == 8'hFF, "R7", "bus after nack", int'(b), 8'hFF);
        check(tx_idx == 3, "R7", "no fetch after nack", tx_idx, 3);
        bus_stop();

        // read header without full match: R5
        bus_start();
        hdr(HDR_R, 0, "R5");
        bus_stop();

        // STOP clears the match: R8
        bus_start();
        hdr(HDR_W, 1, "R2");
        hdr(ADDR[7:0], 1, "R3");
        bus_stop();
        bus_start();
        hdr(HDR_R, 0, "R8");
        bus_stop();

        // wrong low byte clears match, later bytes ignored: R3
        bus_start();
        hdr(HDR_W, 1, "R2");
        hdr(ADDR[7:0], 1, "R3");
        bus_rstart();
        hdr(HDR_W, 1, "R2");
        hdr(8'hB4, 0, "R3");
        check(full_match == 0, "R3", "full_match after bad low byte", int'(full_match), 0);
        wr_expect(8'h77, 0, "R3");
        bus_rstart();
        hdr(HDR_R, 0, "R3");
        bus_stop();

        // wrong upper bits: R2
        bus_start();
        hdr(8'hF6, 0, "R2");
        wr_expect(8'h12, 0, "R2");
        bus_stop();

        // START in the middle of a byte: R10
        bus_start();
        send_bits(8'hF4, 3);
        bus_rstart();
        hdr(HDR_W, 1, "R10");
        hdr(ADDR[7:0], 1, "R10");
        wr_expect(8'h69, 1, "R10");
        bus_stop();
        check(full_match == 0, "R10", "stop seen", int'(full_match), 0);

        wq(4);
        check(rx_exp.size() == 0, "R4", "rx bytes outstanding at end", rx_exp.size(), 0);
        check(sda_pull == 0, "R9", "line released at end", int'(sda_pull), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule